// File: doc/BRIEF.md
# Critical Core Boost Selector

This block picks, once per measurement slice, which single core of a multicore cluster may run at the raised clock frequency during the following slice. When the slice-end strobe arrives it takes a snapshot of the per-thread criticality sums. It walks the snapshot one core per cycle to find the largest value, the smallest value over all cores, and the smallest value over every core except the one boosted now. It then applies two ratio tests against programmable thresholds. A single boost-enable line, or none, is driven to the frequency control logic.

The decision has hysteresis. A boost is granted or moved when the largest criticality exceeds the relevant minimum by more than the ratio alpha. The core boosted now is left out of that minimum. A boost that fails this test is withdrawn only when the boosted core's criticality falls below beta times the largest value. Typical settings are alpha = 1.2 (6/5) and beta = 0.8 (4/5), evaluated every 10 ms. Both ratios are numerator/denominator pairs and are compared by cross-multiplication, so no divider is needed. Between decisions, two fast overrides follow the scheduler. The boost is removed when the boosted thread is scheduled out. The boost is given to a core whose thread is the only active one.

Top module: `crit_boost_sel`

## Requirements
- R1: At most one bit of `boost_en` is ever high; bit i high means core i is boosted.
- R2: After reset no core is boosted and `decide_done` is low.
- R3: With no core boosted, a decision boosts the core with the largest criticality when max*alpha_den > min_all*alpha_num, where min_all is the smallest criticality of all cores; otherwise no core stays boosted.
- R4: With a core boosted, the minimum is taken over the other cores only; when max*alpha_den > that minimum*alpha_num the boost goes to the core with the largest criticality (possibly the same core) and the old core loses it.
- R5: With a core boosted and the R4 test failing, the boost is removed when boosted_crit*beta_den < max*beta_num, and kept unchanged otherwise.
- R6: Ties for the maximum resolve to the lowest core index; a zero minimum with a nonzero maximum passes the alpha test, and an all-zero slice never starts a boost.
- R7: When `slice_end` is sampled high on a clock edge while idle, `decide_done` is high for exactly one cycle, starting N_CORES+1 edges later. The decision's change to `boost_en` appears on that same edge, and `boost_en` does not change during the scan cycles before it.
- R8: While idle, if the boosted core's `sched_out` bit is high, its boost is removed on the next edge.
- R9: While idle, if exactly one `core_active` bit is high, and that core is not scheduled out and not already boosted, that core becomes the only boosted core on the next edge.
- R10: The R8 and R9 overrides are held off while a decision is in progress, and the decision result is applied unchanged; when both would apply, R9 for a different core wins, which also removes the old boost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slice_end | input | 1 | One-cycle strobe marking the end of a measurement slice |
| crit_flat | input | N_CORES*CRIT_W | Criticality sums, core i in bits [i*CRIT_W +: CRIT_W] |
| sched_out | input | N_CORES | Bit i high: the thread of core i is scheduled out |
| core_active | input | N_CORES | Bit i high: the thread of core i is doing useful work |
| alpha_num | input | RATIO_W | Numerator of the move/start ratio |
| alpha_den | input | RATIO_W | Denominator of the move/start ratio |
| beta_num | input | RATIO_W | Numerator of the drop ratio |
| beta_den | input | RATIO_W | Denominator of the drop ratio |
| boost_en | output | N_CORES | One-hot (or zero) boost enable per core |
| decide_done | output | 1 | One-cycle pulse when a slice decision is applied |

## Verification
The embedded properties watch, on every cycle, that the boost vector stays one-hot-or-zero, that it holds still during the scan, that the done pulse lasts one cycle and follows the decide step, and that the scheduled-out drop and the single-active grant take effect on the next edge while idle. Whether the chosen core is right depends on the ratio arithmetic, the tie rule and the hysteresis history, so only the bench scenarios can show it. The bench sweeps every combination of five criticality levels across four cores under two threshold settings, with exact 6/5 and 4/5 boundary cases, and checks each outcome against a model built from the rules. Directed runs cover the all-zero slice, the overrides, and an override raised in the middle of a decision.

// File: rtl/cb_pkg.sv
// Shared types for the critical core boost selector.
// Assumes nothing beyond the enumeration below.
package cb_pkg;

    // Sequencer states of the slice decision engine.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_DECIDE = 2'd2
    } cb_state_e;

endpackage

// File: rtl/cb_scan.sv
// Sequential criticality scanner. On start it snapshots the criticality vector,
// then visits one core per step, tracking the maximum (lowest index on ties),
// the minimum over all cores, the minimum over all cores but the boosted one,
// and the boosted core's own value.
// Assumes: N >= 2, boost state (b_vld, b_idx) is stable while stepping.
module cb_scan #(
    parameter int N  = 4,
    parameter int CW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            step,
    input  logic [N*CW-1:0] crit_flat,
    input  logic            b_vld,
    input  logic [IW-1:0]   b_idx,
    output logic [CW-1:0]   max_val,
    output logic [IW-1:0]   max_idx,
    output logic [CW-1:0]   min_all,
    output logic [CW-1:0]   min_oth,
    output logic [CW-1:0]   b_crit,
    output logic            last
);

    logic [N*CW-1:0] snap;
    logic [IW-1:0]   idx;
    logic [CW-1:0]   cur;
    logic            is_boosted;

    // Value of the core visited in this step.
    assign cur        = snap[idx*CW +: CW];
    // Visiting the currently boosted core.
    assign is_boosted = b_vld && (b_idx == idx);
    // Final step of the walk.
    assign last       = (idx == IW'(N - 1));

    // Snapshot capture and running reductions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap    <= '0;
            idx     <= '0;
            max_val <= '0;
            max_idx <= '0;
            min_all <= '1;
            min_oth <= '1;
            b_crit  <= '0;
        end else if (start) begin
            snap    <= crit_flat;
            idx     <= '0;
            max_val <= '0;
            max_idx <= '0;
            min_all <= '1;
            min_oth <= '1;
            b_crit  <= '0;
        end else if (step) begin
            if (idx == '0 || cur > max_val) begin
                max_val <= cur;
                max_idx <= idx;
            end
            if (cur < min_all) begin
                min_all <= cur;
            end
            if (!is_boosted && cur < min_oth) begin
                min_oth <= cur;
            end
            if (is_boosted) begin
                b_crit <= cur;
            end
            if (!last) begin
                idx <= idx + IW'(1);
            end
        end
    end

    // R7: the walk never points past the last core.
    a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (int'(idx) < N));

    // R6: a new maximum always carries a value at least as large as the old one.
    a_r6_max_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (step && idx != '0) |=> (max_val >= $past(max_val)));

endmodule

// File: rtl/cb_ratio.sv
// Division-free ratio decision. Computes the next boost owner from the scan
// results using cross-multiplied alpha and beta tests with hysteresis.
// Assumes the scan results are settled when the caller samples the outputs.
module cb_ratio #(
    parameter int N  = 4,
    parameter int CW = 16,
    parameter int RW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int PW = CW + RW
) (
    input  logic [CW-1:0] max_val,
    input  logic [IW-1:0] max_idx,
    input  logic [CW-1:0] min_all,
    input  logic [CW-1:0] min_oth,
    input  logic [CW-1:0] b_crit,
    input  logic          b_vld,
    input  logic [IW-1:0] b_idx,
    input  logic [RW-1:0] alpha_num,
    input  logic [RW-1:0] alpha_den,
    input  logic [RW-1:0] beta_num,
    input  logic [RW-1:0] beta_den,
    output logic          nxt_vld,
    output logic [IW-1:0] nxt_idx
);

    logic [CW-1:0] min_sel;
    logic [PW-1:0] lhs_a, rhs_a, lhs_b, rhs_b;
    logic          pass_a, low_b;

    // Minimum used by the alpha test: all cores, or others when boosted.
    assign min_sel = b_vld ? min_oth : min_all;

    // Cross-multiplied products for both ratio tests.
    always_comb begin
        lhs_a = PW'(max_val) * PW'(alpha_den);
        rhs_a = PW'(min_sel) * PW'(alpha_num);
        lhs_b = PW'(b_crit)  * PW'(beta_den);
        rhs_b = PW'(max_val) * PW'(beta_num);
    end

    assign pass_a = lhs_a > rhs_a;
    assign low_b  = lhs_b < rhs_b;

    // Start/move, drop, or keep.
    always_comb begin
        nxt_vld = b_vld;
        nxt_idx = b_idx;
        if (pass_a) begin
            nxt_vld = 1'b1;
            nxt_idx = max_idx;
        end else if (b_vld && low_b) begin
            nxt_vld = 1'b0;
        end
    end

    // R1: a granted boost always names an existing core.
    always_comb begin
        if (nxt_vld) begin
            a_r1_pick_range: assert (int'(nxt_idx) < N);
        end
    end

endmodule

// File: rtl/cb_solo.sv
// Single-active-thread detector: flags when exactly one core is active and
// reports its index.
// Assumes core_active is synchronous to the consuming clock.
module cb_solo #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CNTW = $clog2(N + 1)
) (
    input  logic [N-1:0]  core_active,
    output logic          solo,
    output logic [IW-1:0] solo_idx
);

    logic [CNTW-1:0] act_cnt;

    // Count active cores and remember the highest active index.
    always_comb begin
        act_cnt  = '0;
        solo_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (core_active[i]) begin
                act_cnt  = act_cnt + CNTW'(1);
                solo_idx = IW'(i);
            end
        end
    end

    assign solo = (act_cnt == CNTW'(1));

    // R9: a reported lone core is indeed active.
    always_comb begin
        if (solo) begin
            a_r9_solo_active: assert (core_active[solo_idx]);
        end
    end

endmodule

// File: rtl/crit_boost_sel.sv
// Critical core boost selector top. Holds the boosted core (index + valid),
// runs a scan-then-decide sequence after each slice-end strobe, and applies
// the scheduled-out drop and single-active grant overrides while idle.
// Assumes: N_CORES >= 2; slice_end strobes are at least N_CORES+2 cycles apart
// (strobes arriving mid-decision are ignored).
module crit_boost_sel #(
    parameter int N_CORES = 4,
    parameter int CRIT_W  = 16,
    parameter int RATIO_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slice_end,
    input  logic [N_CORES*CRIT_W-1:0] crit_flat,
    input  logic [N_CORES-1:0]        sched_out,
    input  logic [N_CORES-1:0]        core_active,
    input  logic [RATIO_W-1:0]        alpha_num,
    input  logic [RATIO_W-1:0]        alpha_den,
    input  logic [RATIO_W-1:0]        beta_num,
    input  logic [RATIO_W-1:0]        beta_den,
    output logic [N_CORES-1:0]        boost_en,
    output logic                      decide_done
);
    import cb_pkg::*;

    localparam int IW = (N_CORES > 1) ? $clog2(N_CORES) : 1;

    cb_state_e     state;
    logic          b_vld;
    logic [IW-1:0] b_idx;
    logic          start, step, last;
    logic [CRIT_W-1:0] max_val, min_all, min_oth, b_crit;
    logic [IW-1:0] max_idx;
    logic          nxt_vld;
    logic [IW-1:0] nxt_idx;
    logic          solo;
    logic [IW-1:0] solo_idx;
    logic          idle, grant_solo, drop_sched;

    assign idle  = (state == ST_IDLE);
    assign start = idle && slice_end;
    assign step  = (state == ST_SCAN);

    // Override conditions evaluated while idle.
    assign grant_solo = solo && !sched_out[solo_idx] && !(b_vld && b_idx == solo_idx);
    assign drop_sched = b_vld && sched_out[b_idx];

    cb_scan #(.N(N_CORES), .CW(CRIT_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .step      (step),
        .crit_flat (crit_flat),
        .b_vld     (b_vld),
        .b_idx     (b_idx),
        .max_val   (max_val),
        .max_idx   (max_idx),
        .min_all   (min_all),
        .min_oth   (min_oth),
        .b_crit    (b_crit),
        .last      (last)
    );

    cb_ratio #(.N(N_CORES), .CW(CRIT_W), .RW(RATIO_W)) u_ratio (
        .max_val   (max_val),
        .max_idx   (max_idx),
        .min_all   (min_all),
        .min_oth   (min_oth),
        .b_crit    (b_crit),
        .b_vld     (b_vld),
        .b_idx     (b_idx),
        .alpha_num (alpha_num),
        .alpha_den (alpha_den),
        .beta_num  (beta_num),
        .beta_den  (beta_den),
        .nxt_vld   (nxt_vld),
        .nxt_idx   (nxt_idx)
    );

    cb_solo #(.N(N_CORES)) u_solo (
        .core_active (core_active),
        .solo        (solo),
        .solo_idx    (solo_idx)
    );

    // Sequencer, boost owner register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            b_vld       <= 1'b0;
            b_idx       <= '0;
            decide_done <= 1'b0;
        end else begin
            decide_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (slice_end) begin
                        state <= ST_SCAN;
                    end
                    if (grant_solo) begin
                        b_vld <= 1'b1;
                        b_idx <= solo_idx;
                    end else if (drop_sched) begin
                        b_vld <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (last) begin
                        state <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    b_vld       <= nxt_vld;
                    b_idx       <= nxt_idx;
                    decide_done <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the owner into per-core enables.
    generate
        for (genvar g = 0; g < N_CORES; g++) begin : g_en
            assign boost_en[g] = b_vld && (b_idx == IW'(g));
        end
    endgenerate

    // R1: never more than one boosted core.
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(boost_en));

    // R7: boost vector frozen during the scan.
    a_r7_scan_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |=> $stable(boost_en));

    // R7: decide step is followed by a done pulse.
    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE) |=> decide_done);

    // R7: done lasts one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        decide_done |=> !decide_done);

    // R8: a scheduled-out boosted core loses its boost next edge.
    a_r8_sched_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && b_vld && sched_out[b_idx]) |=> !boost_en[$past(b_idx)]);

    // R9: a lone active core gains the boost next edge.
    a_r9_solo_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && solo && !sched_out[solo_idx]) |=> boost_en[$past(solo_idx)]);

endmodule

// File: tb/sim_crit_boost_sel.sv
module sim_crit_boost_sel;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int CW = 16;
    localparam int RW = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            slice_end;
    logic [N*CW-1:0] crit_flat;
    logic [N-1:0]    sched_out;
    logic [N-1:0]    core_active;
    logic [RW-1:0]   alpha_num, alpha_den, beta_num, beta_den;
    logic [N-1:0]    boost_en;
    logic            decide_done;

    int n_checks = 0;
    int n_fail   = 0;
    int cur      = -1;
    bit finished = 1'b0;

    crit_boost_sel #(.N_CORES(N), .CRIT_W(CW), .RATIO_W(RW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .slice_end   (slice_end),
        .crit_flat   (crit_flat),
        .sched_out   (sched_out),
        .core_active (core_active),
        .alpha_num   (alpha_num),
        .alpha_den   (alpha_den),
        .beta_num    (beta_num),
        .beta_den    (beta_den),
        .boost_en    (boost_en),
        .decide_done (decide_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] onehot(input int i);
        return (i < 0) ? '0 : (N'(1) << i);
    endfunction

    function automatic int level(input int k);
        case (k)
            0: return 0;
            1: return 4;
            2: return 5;
            3: return 6;
            default: return 8;
        endcase
    endfunction

    // Reference decision from the requirements (R3..R6).
    task automatic model(input int c[N], input int owner, input int an, input int ad,
                         input int bn, input int bd, output int nxt, output string tag);
        int mx = c[0];
        int mi = 0;
        int mn = 1 << 30;
        for (int i = 1; i < N; i++) if (c[i] > mx) begin mx = c[i]; mi = i; end
        for (int i = 0; i < N; i++) if (i != owner && c[i] < mn) mn = c[i];
        if (mx * ad > mn * an) begin
            nxt = mi;
            tag = (owner < 0) ? "R3" : "R4";
        end else if (owner >= 0 && c[owner] * bd < mx * bn) begin
            nxt = -1;
            tag = "R5";
        end else begin
            nxt = owner;
            tag = (owner < 0) ? "R3" : "R5";
        end
        if (mn == 0 || (c[mi] == c[0] && mi != 0)) tag = {tag, "/R6"};
    endtask

    // One slice: strobe, check hold before done, then done and result (R7).
    task automatic run_slice(input int c[N], input int an, input int ad, input int bn, input int bd);
        int    nxt;
        string tag;
        model(c, cur, an, ad, bn, bd, nxt, tag);
        for (int i = 0; i < N; i++) crit_flat[i*CW +: CW] = CW'(c[i]);
        slice_end = 1'b1;
        @(negedge clk);
        slice_end = 1'b0;
        repeat (N) @(negedge clk);
        chk(!decide_done && boost_en == onehot(cur), "R7 hold", {boost_en, decide_done}, {onehot(cur), 1'b0});
        @(negedge clk);
        chk(decide_done == 1'b1, "R7 done", decide_done, 1);
        chk(boost_en == onehot(nxt), tag, boost_en, onehot(nxt));
        cur = nxt;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cur = -1;
        @(negedge clk);
    endtask

    initial begin
        int c[N];
        slice_end   = 1'b0;
        crit_flat   = '0;
        sched_out   = '0;
        core_active = '1;
        alpha_num = 8'd6; alpha_den = 8'd5; beta_num = 8'd4; beta_den = 8'd5;
        @(negedge clk);
        do_reset();
        chk(boost_en == '0 && !decide_done, "R2 reset", {boost_en, decide_done}, 0);

        // Sweep all level combinations, alpha 6/5 beta 4/5 (R3 R4 R5 R6 R1).
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int d = 0; d < 5; d++)
                    for (int e = 0; e < 5; e++) begin
                        c = '{level(a), level(b), level(d), level(e)};
                        run_slice(c, 6, 5, 4, 5);
                    end

        // Second sweep, alpha 3/2 beta 1/2.
        alpha_num = 8'd3; alpha_den = 8'd2; beta_num = 8'd1; beta_den = 8'd2;
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int d = 0; d < 5; d++)
                    for (int e = 0; e < 5; e++) begin
                        c = '{level(e), level(d), level(a), level(b)};
                        run_slice(c, 3, 2, 1, 2);
                    end

        // Directed R6: all zero, then tie with zero minimum.
        alpha_num = 8'd6; alpha_den = 8'd5; beta_num = 8'd4; beta_den = 8'd5;
        do_reset();
        c = '{0, 0, 0, 0};
        run_slice(c, 6, 5, 4, 5);
        chk(boost_en == '0, "R6 all zero", boost_en, 0);
        c = '{7, 9, 9, 0};
        run_slice(c, 6, 5, 4, 5);
        chk(boost_en == 4'b0010, "R6 tie lowest", boost_en, 2);

        // R8: scheduled-out boosted core dropped next edge.
        sched_out = 4'b0010;
        @(negedge clk);
        chk(boost_en == '0, "R8 drop", boost_en, 0);
        sched_out = '0;
        cur = -1;

        // R9: single active core boosted next edge, and it stays.
        core_active = 4'b0100;
        @(negedge clk);
        chk(boost_en == 4'b0100, "R9 grant", boost_en, 4);
        @(negedge clk);
        chk(boost_en == 4'b0100, "R9 steady", boost_en, 4);
        cur = 2;

        // R10: override raised mid-decision is held off until idle.
        c = '{5, 5, 9, 5};
        for (int i = 0; i < N; i++) crit_flat[i*CW +: CW] = CW'(c[i]);
        slice_end = 1'b1;
        @(negedge clk);
        slice_end = 1'b0;
        sched_out = 4'b0100;
        repeat (N) @(negedge clk);
        chk(boost_en == 4'b0100 && !decide_done, "R10 held", boost_en, 4);
        @(negedge clk);
        chk(boost_en == 4'b0100 && decide_done, "R10 decision kept", boost_en, 4);
        @(negedge clk);
        chk(boost_en == '0, "R10 drop after idle", boost_en, 0);

        // R10: grant to a different lone core replaces a scheduled-out owner.
        sched_out = '0;
        core_active = 4'b0001;
        @(negedge clk);
        chk(boost_en == 4'b0001, "R9 grant core0", boost_en, 1);
        core_active = 4'b1000;
        sched_out   = 4'b0001;
        @(negedge clk);
        chk(boost_en == 4'b1000, "R10 priority", boost_en, 8);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule